// File: doc/BRIEF.md
# Chip-Select Bank Address Matcher

This block decides which of a small set of programmable memory banks an outgoing external bus request belongs to. Each bank has two configuration words. The base word holds the base address, an expected address-type code, a valid bit, a write-protect bit, a burst-inhibit bit and a port-size field. The option word holds an address mask and an address-type mask. The block compares the request against every bank in parallel and picks the lowest-numbered bank that matches. It drives a one-hot chip-select vector and reports the selected bank's attributes in the same cycle.

A write to a bank marked write-protected does not select that bank. The block drives no chip select and gives no hit, so the bus cycle is left to outside termination. It raises a combinational violation indication and sets a sticky per-bank flag in a status word. Software clears that flag by writing 1 to it. When the request comes from an external master, the address type used for the comparison is replaced by binary 100. Configuration is written through a simple single-cycle write port. The status flags are visible on an output port.

Top module: `csm_matcher`

## Requirements
- R1: A bank matches only when `req_addr[31:12]` and the base word bits [31:12] are equal in every bit position where the option word bits [31:12] hold 1. Address bits [11:0] are never compared.
- R2: The request's 3-bit address type is compared with base word bits [11:9] only in the positions where option word bits [11:9] hold 1. An all-zero type mask matches any type.
- R3: When several banks match, the lowest-numbered one is selected and reported on `bank_idx`.
- R4: A bank whose base word bit 0 (valid) is 0 never matches.
- R5: `cs` is one-hot with bit `bank_idx` set when `hit` is 1. `cs` is all zero when `hit` is 0. `hit` is 0 whenever `req_valid` is 0. `bank_idx` is 0 when no bank matches.
- R6: When the selected bank has base word bit 8 (write protect) set and `req_write` is 1, `hit` is 0, `cs` is zero and `wp_violation` is 1. A read of the same bank hits normally.
- R7: A write-protect violation sets `viol_flags[bank_idx]` at the next clock edge. The flag stays set until a configuration write to the status word (select 8) has 1 in that bit. A violation in the same cycle as the clear leaves the flag set.
- R8: When `req_ext_master` is 1, the type used for R2 is 3'b100 whatever `req_type` holds.
- R9: `port_size` (base word bits [6:5]) and `burst_inhibit` (base word bit 7) show the selected bank's fields when `hit` is 1, and are 0 otherwise.
- R10: After reset, every configuration word and every status flag is 0, so no request hits. Configuration selects 0 to 3 are the base words of banks 0 to 3, and selects 4 to 7 are their option words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration word select (0-3 base, 4-7 option, 8 status) |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | A bus request is present |
| req_addr | input | 32 | Request address |
| req_type | input | 3 | Request address-type code |
| req_ext_master | input | 1 | Request originates from an external master |
| req_write | input | 1 | Request is a write |
| hit | output | 1 | A bank is selected and will be driven |
| cs | output | 4 | One-hot chip selects |
| bank_idx | output | 2 | Index of the lowest matching bank |
| port_size | output | 2 | Port-size field of the selected bank |
| burst_inhibit | output | 1 | Burst-inhibit bit of the selected bank |
| wp_violation | output | 1 | Write to a protected bank this cycle |
| viol_flags | output | 4 | Sticky per-bank violation flags |

## Verification
The hardest situation to reach is a violation arriving in the same cycle as a write-one-to-clear of the same flag. It needs the request and the status write to line up on one edge. The bench drives both from one task before a single clock edge. The random phase programs banks with overlapping bases and a few coarse masks, so that multi-bank matches, priority decisions and protected writes occur often. Random external-master requests mixed with narrow type masks reach the forced-type comparison.

// File: rtl/csm_pkg.sv
package csm_pkg;
    localparam int BR_VALID   = 0;
    localparam int BR_PS_LSB  = 5;
    localparam int BR_BI      = 7;
    localparam int BR_WP      = 8;
    localparam int BR_AT_LSB  = 9;
    localparam int OR_ATM_LSB = 9;
    localparam int CMP_LSB    = 12;
    localparam int TYPE_W     = 3;
    localparam int PS_W       = 2;
    localparam logic [TYPE_W-1:0] EXT_MASTER_TYPE = 3'b100;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_OPTION = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/csm_regs.sv
module csm_regs
    import csm_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 4,
    localparam int BA_W   = ADDR_W - CMP_LSB,
    localparam int IDX_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    input  logic                           set_viol,
    input  logic [IDX_W-1:0]               set_idx,
    output logic [N_BANKS-1:0]             valid_q,
    output logic [N_BANKS-1:0]             wp_q,
    output logic [N_BANKS-1:0]             bi_q,
    output logic [N_BANKS-1:0][PS_W-1:0]   ps_q,
    output logic [N_BANKS-1:0][TYPE_W-1:0] at_q,
    output logic [N_BANKS-1:0][BA_W-1:0]   base_q,
    output logic [N_BANKS-1:0][TYPE_W-1:0] atm_q,
    output logic [N_BANKS-1:0][BA_W-1:0]   mask_q,
    output logic [N_BANKS-1:0]             flags_q
);
    cfg_kind_e          kind;
    logic [IDX_W-1:0]   widx;
    logic [N_BANKS-1:0] clr_vec;
    logic [N_BANKS-1:0] set_vec;

    always_comb begin
        kind = SEL_NONE;
        widx = '0;
        if (int'(cfg_sel) < N_BANKS) begin
            kind = SEL_BASE;
            widx = IDX_W'(cfg_sel);
        end else if (int'(cfg_sel) < 2 * N_BANKS) begin
            kind = SEL_OPTION;
            widx = IDX_W'(int'(cfg_sel) - N_BANKS);
        end else if (int'(cfg_sel) == 2 * N_BANKS) begin
            kind = SEL_STATUS;
        end
    end

    always_comb begin
        clr_vec = '0;
        set_vec = '0;
        if (cfg_we && kind == SEL_STATUS) clr_vec = cfg_wdata[N_BANKS-1:0];
        if (set_viol) set_vec[set_idx] = 1'b1;
    end

    genvar b;
    generate
        for (b = 0; b < N_BANKS; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[b] <= 1'b0;
                    wp_q[b]    <= 1'b0;
                    bi_q[b]    <= 1'b0;
                    ps_q[b]    <= '0;
                    at_q[b]    <= '0;
                    base_q[b]  <= '0;
                    atm_q[b]   <= '0;
                    mask_q[b]  <= '0;
                end else if (cfg_we && widx == IDX_W'(b)) begin
                    unique case (kind)
                        SEL_BASE: begin
                            valid_q[b] <= cfg_wdata[BR_VALID];
                            wp_q[b]    <= cfg_wdata[BR_WP];
                            bi_q[b]    <= cfg_wdata[BR_BI];
                            ps_q[b]    <= cfg_wdata[BR_PS_LSB +: PS_W];
                            at_q[b]    <= cfg_wdata[BR_AT_LSB +: TYPE_W];
                            base_q[b]  <= cfg_wdata[ADDR_W-1:CMP_LSB];
                        end
                        SEL_OPTION: begin
                            atm_q[b]   <= cfg_wdata[OR_ATM_LSB +: TYPE_W];
                            mask_q[b]  <= cfg_wdata[ADDR_W-1:CMP_LSB];
                        end
                        SEL_STATUS, SEL_NONE: ;
                    endcase
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    logic unused_wdata;
    assign unused_wdata = ^{cfg_wdata[BR_PS_LSB-1:1]};
endmodule

// File: rtl/csm_bank_cmp.sv
module csm_bank_cmp
    import csm_pkg::*;
#(
    parameter int BA_W = 20
) (
    input  logic              valid,
    input  logic [BA_W-1:0]   base,
    input  logic [BA_W-1:0]   mask,
    input  logic [TYPE_W-1:0] at,
    input  logic [TYPE_W-1:0] atm,
    input  logic [BA_W-1:0]   req_hi,
    input  logic [TYPE_W-1:0] eff_type,
    output logic              match
);
    logic addr_eq;
    logic type_eq;

    always_comb begin
        addr_eq = ((req_hi ^ base) & mask) == '0;
        type_eq = ((eff_type ^ at) & atm) == '0;
        match   = valid && addr_eq && type_eq;
    end
endmodule

// File: rtl/csm_prio.sv
module csm_prio #(
    parameter int N_BANKS = 4,
    localparam int IDX_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic [N_BANKS-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_BANKS - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/csm_matcher.sv
module csm_matcher
    import csm_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int ADDR_W  = 32,
    localparam int SEL_W  = $clog2(2 * N_BANKS + 1),
    localparam int IDX_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
    localparam int BA_W   = ADDR_W - CMP_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [TYPE_W-1:0]  req_type,
    input  logic               req_ext_master,
    input  logic               req_write,
    output logic               hit,
    output logic [N_BANKS-1:0] cs,
    output logic [IDX_W-1:0]   bank_idx,
    output logic [PS_W-1:0]    port_size,
    output logic               burst_inhibit,
    output logic               wp_violation,
    output logic [N_BANKS-1:0] viol_flags
);
    logic [N_BANKS-1:0]             valid_q, wp_q, bi_q;
    logic [N_BANKS-1:0][PS_W-1:0]   ps_q;
    logic [N_BANKS-1:0][TYPE_W-1:0] at_q, atm_q;
    logic [N_BANKS-1:0][BA_W-1:0]   base_q, mask_q;
    logic [N_BANKS-1:0]             match_vec;
    logic [TYPE_W-1:0]              eff_type;
    logic                           any_match;
    logic [IDX_W-1:0]               win_idx;
    logic                           win_wp;

    csm_regs #(.N_BANKS(N_BANKS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .set_viol (wp_violation),
        .set_idx  (win_idx),
        .valid_q  (valid_q),
        .wp_q     (wp_q),
        .bi_q     (bi_q),
        .ps_q     (ps_q),
        .at_q     (at_q),
        .base_q   (base_q),
        .atm_q    (atm_q),
        .mask_q   (mask_q),
        .flags_q  (viol_flags)
    );

    assign eff_type = req_ext_master ? EXT_MASTER_TYPE : req_type;

    genvar b;
    generate
        for (b = 0; b < N_BANKS; b++) begin : g_cmp
            csm_bank_cmp #(.BA_W(BA_W)) u_cmp (
                .valid   (valid_q[b]),
                .base    (base_q[b]),
                .mask    (mask_q[b]),
                .at      (at_q[b]),
                .atm     (atm_q[b]),
                .req_hi  (req_addr[ADDR_W-1:CMP_LSB]),
                .eff_type(eff_type),
                .match   (match_vec[b])
            );
        end
    endgenerate

    csm_prio #(.N_BANKS(N_BANKS)) u_prio (
        .req(match_vec),
        .any(any_match),
        .idx(win_idx)
    );

    always_comb begin
        win_wp        = wp_q[win_idx];
        wp_violation  = req_valid && any_match && req_write && win_wp;
        hit           = req_valid && any_match && !wp_violation;
        bank_idx      = win_idx;
        cs            = '0;
        port_size     = '0;
        burst_inhibit = 1'b0;
        if (hit) begin
            cs[win_idx]   = 1'b1;
            port_size     = ps_q[win_idx];
            burst_inhibit = bi_q[win_idx];
        end
    end

    logic unused_addr;
    assign unused_addr = ^{req_addr[CMP_LSB-1:0]};
endmodule

// File: rtl/csm_matcher_chk.sv
module csm_matcher_chk #(
    parameter int N_BANKS = 4,
    parameter int SEL_W   = 4,
    parameter int IDX_W   = 2,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [SEL_W-1:0]   cfg_sel,
    input logic [ADDR_W-1:0]  cfg_wdata,
    input logic               req_valid,
    input logic               req_write,
    input logic               hit,
    input logic [N_BANKS-1:0] cs,
    input logic [IDX_W-1:0]   bank_idx,
    input logic [1:0]         port_size,
    input logic               burst_inhibit,
    input logic               wp_violation,
    input logic [N_BANKS-1:0] viol_flags
);
    logic [N_BANKS-1:0] clr_mask;
    assign clr_mask = (cfg_we && int'(cfg_sel) == 2 * N_BANKS) ? cfg_wdata[N_BANKS-1:0] : '0;

    a_r5_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs) && (hit == (cs != '0)));

    a_r5_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !hit && cs == '0);

    a_r3_cs_matches_idx: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> cs[bank_idx]);

    a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wp_violation |-> req_write && !hit && cs == '0);

    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wp_violation |=> viol_flags[$past(bank_idx)]);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((viol_flags & $past(viol_flags & ~clr_mask)) == $past(viol_flags & ~clr_mask)));

    a_r9_attr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> port_size == 2'b00 && !burst_inhibit);
endmodule

bind csm_matcher csm_matcher_chk #(
    .N_BANKS(N_BANKS), .SEL_W(SEL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
    .hit(hit), .cs(cs), .bank_idx(bank_idx), .port_size(port_size),
    .burst_inhibit(burst_inhibit), .wp_violation(wp_violation),
    .viol_flags(viol_flags)
);

// File: tb/test_csm_matcher.sv
module test_csm_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_type = '0;
    logic        req_ext_master = 1'b0;
    logic        req_write = 1'b0;
    logic        hit;
    logic [3:0]  cs;
    logic [1:0]  bank_idx;
    logic [1:0]  port_size;
    logic        burst_inhibit;
    logic        wp_violation;
    logic [3:0]  viol_flags;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_base [4];
    logic [31:0] m_opt  [4];
    logic [3:0]  m_flags;

    always #2.5 clk = ~clk;

    csm_matcher i_csm_matcher (.*);

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic bank_match(int b, logic [31:0] a, logic [2:0] t, logic ext);
        logic [2:0] et = ext ? 3'b100 : t;
        logic am = ((a[31:12] ^ m_base[b][31:12]) & m_opt[b][31:12]) == 0;
        logic tm = ((et ^ m_base[b][11:9]) & m_opt[b][11:9]) == 0;
        return m_base[b][0] && am && tm;
    endfunction

    task automatic cfg_write(int sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 4) m_base[sel] = d;
        else if (sel < 8) m_opt[sel-4] = d;
        else if (sel == 8) m_flags = m_flags & ~d[3:0];
    endtask

    // Drive a request, check combinational outputs, then clock once and check flags.
    task automatic do_req(logic [31:0] a, logic [2:0] t, logic ext, logic wr,
                          logic clr_same, string tag);
        int  w = -1;
        logic e_hit, e_wpv;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_type = t; req_ext_master = ext; req_write = wr;
        if (clr_same) begin cfg_we = 1'b1; cfg_sel = 4'd8; cfg_wdata = 32'hF; end
        for (int b = 3; b >= 0; b--) if (bank_match(b, a, t, ext)) w = b;
        e_wpv = (w >= 0) && wr && m_base[w][8];
        e_hit = (w >= 0) && !e_wpv;
        #1;
        check({tag, " hit"}, 32'(hit), 32'(e_hit));
        check({tag, " R5 cs"}, 32'(cs), e_hit ? (32'd1 << w) : 32'd0);
        check({tag, " R3 bank_idx"}, 32'(bank_idx), (w >= 0) ? 32'(w) : 32'd0);
        check({tag, " R6 wp_violation"}, 32'(wp_violation), 32'(e_wpv));
        check({tag, " R9 attrs"}, {29'd0, port_size, burst_inhibit},
              e_hit ? {29'd0, m_base[w][6:5], m_base[w][7]} : 32'd0);
        if (clr_same) m_flags = 4'd0;
        if (e_wpv) m_flags[w] = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        check({tag, " R7 flags"}, 32'(viol_flags), 32'(m_flags));
    endtask

    function automatic logic [31:0] mk_base(logic [19:0] ba, logic [2:0] at, logic wp,
                                            logic bi, logic [1:0] ps, logic v);
        return {ba, at, wp, bi, ps, 4'd0, v};
    endfunction

    initial begin
        void'($urandom(32'd1234));
        m_flags = '0;
        for (int b = 0; b < 4; b++) begin m_base[b] = '0; m_opt[b] = '0; end
        repeat (3) @(negedge clk);
        check("R10 reset flags", 32'(viol_flags), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: nothing programmed, nothing hits
        do_req(32'h0000_0000, 3'd0, 1'b0, 1'b0, 1'b0, "R10 empty");
        // R4: valid clear with full match otherwise
        cfg_write(4, 32'hFFFF_F000);
        cfg_write(0, mk_base(20'h12345, 3'd0, 1'b0, 1'b0, 2'd1, 1'b0));
        do_req(32'h1234_5ABC, 3'd0, 1'b0, 1'b0, 1'b0, "R4 invalid");
        // R1: valid, exact mask
        cfg_write(0, mk_base(20'h12345, 3'd0, 1'b0, 1'b1, 2'd2, 1'b1));
        do_req(32'h1234_5FFF, 3'd5, 1'b0, 1'b0, 1'b0, "R1 exact");
        do_req(32'h1234_4000, 3'd5, 1'b0, 1'b0, 1'b0, "R1 miss");
        // R3: bank 1 coarse mask overlapping, bank 0 wins then bank 1 alone
        cfg_write(5, 32'hF000_0000);
        cfg_write(1, mk_base(20'h10000, 3'd0, 1'b0, 1'b0, 2'd3, 1'b1));
        do_req(32'h1234_5000, 3'd0, 1'b0, 1'b0, 1'b0, "R3 overlap");
        do_req(32'h1FFF_0000, 3'd0, 1'b0, 1'b0, 1'b0, "R3 lower only");
        // R2: type mask on bank 2
        cfg_write(6, 32'h0000_0E00 | 32'hFF00_0000);
        cfg_write(2, mk_base(20'hAB000, 3'd3, 1'b0, 1'b0, 2'd1, 1'b1));
        do_req(32'hAB00_0000, 3'd3, 1'b0, 1'b0, 1'b0, "R2 type ok");
        do_req(32'hAB00_0000, 3'd2, 1'b0, 1'b0, 1'b0, "R2 type bad");
        // R8: external master forces 100
        cfg_write(3, mk_base(20'hCD000, 3'd4, 1'b0, 1'b1, 2'd0, 1'b1));
        cfg_write(7, 32'hFF00_0E00);
        do_req(32'hCD00_0000, 3'd1, 1'b1, 1'b0, 1'b0, "R8 ext hit");
        do_req(32'hCD00_0000, 3'd4, 1'b0, 1'b0, 1'b0, "R8 int same");
        do_req(32'hAB00_0000, 3'd3, 1'b1, 1'b0, 1'b0, "R8 ext miss");
        // R6/R7: protect bank 2
        cfg_write(2, mk_base(20'hAB000, 3'd3, 1'b1, 1'b0, 2'd1, 1'b1));
        do_req(32'hAB00_0000, 3'd3, 1'b0, 1'b0, 1'b0, "R6 read ok");
        do_req(32'hAB00_0000, 3'd3, 1'b0, 1'b1, 1'b0, "R6 write blocked");
        do_req(32'h0000_0000, 3'd0, 1'b0, 1'b0, 1'b0, "R7 sticky");
        cfg_write(8, 32'h0000_0008);
        check("R7 clear other bit", 32'(viol_flags), 32'(m_flags));
        cfg_write(8, 32'h0000_0004);
        check("R7 clear own bit", 32'(viol_flags), 32'(m_flags));
        do_req(32'hAB00_0000, 3'd3, 1'b0, 1'b1, 1'b1, "R7 set wins");
        cfg_write(8, 32'h0000_000F);
        // R5: req_valid low with matching address
        @(negedge clk);
        req_addr = 32'h1234_5000; req_valid = 1'b0; #1;
        check("R5 idle", {30'd0, hit, |cs}, 0);

        // Constrained random
        for (int it = 0; it < 400; it++) begin
            if (it % 50 == 0) begin
                for (int b = 0; b < 4; b++) begin
                    logic [19:0] ba = {3'($urandom % 4), 17'($urandom)};
                    logic [19:0] mk;
                    case ($urandom % 4)
                        0: mk = 20'hFFFFF; 1: mk = 20'hFFF00;
                        2: mk = 20'hE0000; default: mk = 20'h00000;
                    endcase
                    cfg_write(4 + b, {mk, 3'($urandom), 9'd0});
                    cfg_write(b, mk_base(ba, 3'($urandom), ($urandom % 3) == 0,
                                         1'($urandom), 2'($urandom), ($urandom % 4) != 0));
                end
            end
            begin
                int j = $urandom % 4;
                logic [31:0] a = {m_base[j][31:12], 12'($urandom)};
                if ($urandom % 4 == 0) a[12 + ($urandom % 20)] ^= 1'b1;
                do_req(a, 3'($urandom), ($urandom % 5) == 0, 1'($urandom),
                       ($urandom % 20) == 0, "R1 R2 R3 random");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule